// File: doc/BRIEF.md
# Real-Time Counter with Alarms

This peripheral keeps time as a 32-bit count that carries four fractional bits, so whole seconds are the count shifted right by four. Each count step takes an even number of oscillator pulses, set by a programmable divider, and the oscillator reaches the block as a one-cycle enable (`osc_en`) in the bus clock domain. Two compare registers raise alarm events when the count equals them. A periodic event fires once per second, when the fraction wraps to zero. A shared status word holds the event flags, which are cleared by writing one, next to their plain read/write enable bits. The interrupt line is the OR of every flag that is enabled.

Software reaches everything through a flat register bus: an address, a write strobe, write data, and read data that is combinational from the address. The prescaler is a two-state machine. In `PS_HALTED` its phase counters are held at zero. In `PS_RUNNING` it counts oscillator pulses. It takes the transition `PS_HALTED -> PS_RUNNING` when the clock-select register holds 0x3, and the transition `PS_RUNNING -> PS_HALTED` when that register holds any other value. Each change shows one cycle after the register is written. A scratch word is kept for software and has no effect on counting.

Top module: `rtc_tick_alarm`

## Requirements
- R1: After reset, the count, both alarm registers, the status word, clock select and the scratch word read 0, the divider reads 1023 (0x3FF), and `irq` is 0.
- R2: The scratch word at 0x40 reads back the last 32-bit value written and does not disturb the count.
- R3: With clock select at 0x3, the count grows by one for every 2*(DIV+1) pulses of `osc_en`, counted from a fresh start of the prescaler.
- R4: While clock select holds any value other than 0x3, `osc_en` pulses leave the count unchanged.
- R5: Counting wraps from 0xFFFFFFFF to 0x00000000.
- R6: A bus write to the count (0x00) takes effect on the next cycle. It overrides an increment that falls in the same cycle.
- R7: Status bit 1 (tick flag) is set by every increment whose result has its low 4 bits equal to zero. It is set whether or not its enable is on.
- R8: Status bit 0 is set in each cycle after the one where the count equals alarm0 (0x04) while bit 2 is 1. Status bit 4 is set the same way from alarm1 (0x18) and bit 6. With its enable at 0, a flag stays 0.
- R9: In a status (0x08) write, a 1 on flag bits 0, 1 or 4 clears that flag and a 0 keeps it. Enable bits 2, 3 and 6 take the written value. Bits 5 and 7 upward read 0.
- R10: If a flag's set condition holds in the same cycle as a write-one clear, the set wins. An alarm's set condition uses the enable value from before that write.
- R11: `irq` is 1 exactly when some flag bit and its enable bit are both 1 (0/2, 1/3, 4/6).
- R12: The divider is at 0x0C and clock select at 0x1C. Reads at unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One-cycle pulse per oscillator period |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt: OR of enabled flags |

## Verification
The collision that matters here is a write-one clear landing in the same cycle as a flag's set condition. For the tick flag, the bench gives three oscillator pulses and then issues the status write together with the fourth, prescaler-completing pulse while the count sits at 0x1F. It judges that the flag still reads 1 and that the count moved to 0x20. For alarm0, the count is left equal to the compare value. The flag is then cleared with the enable kept on, and again while the enable is turned off. The flag must survive both writes, and only a third write clears it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    // register byte offsets (decoded by software; order fixed)
    localparam logic [7:0] OFS_COUNT   = 8'h00;
    localparam logic [7:0] OFS_ALARM0  = 8'h04;
    localparam logic [7:0] OFS_STATUS  = 8'h08;
    localparam logic [7:0] OFS_DIV     = 8'h0C;
    localparam logic [7:0] OFS_ALARM1  = 8'h18;
    localparam logic [7:0] OFS_SEL     = 8'h1C;
    localparam logic [7:0] OFS_SCRATCH = 8'h40;

    localparam int NUM_ALARMS = 2;
    localparam int FRAC_BITS  = 4;
    localparam int STAT_W     = 8;

    // status word bit positions
    localparam int B_AL0     = 0;
    localparam int B_TICK    = 1;
    localparam int B_AL0_EN  = 2;
    localparam int B_TICK_EN = 3;
    localparam int B_AL1     = 4;
    localparam int B_AL1_EN  = 6;

    localparam logic [1:0] SEL_RUN = 2'b11;

    typedef enum logic {PS_HALTED, PS_RUNNING} ps_state_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             step
);
    import rtc_pkg::*;

    ps_state_e        state_q, state_d;
    logic [DIV_W-1:0] half_q;
    logic             phase_q;
    logic             half_end;

    assign half_end = (half_q >= div);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_HALTED:  if (run)  state_d = PS_RUNNING;
            PS_RUNNING: if (!run) state_d = PS_HALTED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_HALTED;
        else        state_q <= state_d;
    end

    // two half-periods of (div+1) pulses each make one step
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == PS_HALTED) begin
            half_q  <= '0;
            phase_q <= 1'b0;
        end else if (osc_en) begin
            if (half_end) begin
                half_q  <= '0;
                phase_q <= ~phase_q;
            end else begin
                half_q <= half_q + 1'b1;
            end
        end
    end

    always_comb begin
        step = (state_q == PS_RUNNING) && osc_en && half_end && phase_q;
    end

    // R4
    halted_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !step);
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else if (step) cnt <= cnt + 1'b1;
    end

    // R6
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));
    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> cnt == $past(cnt) + W'(1));
    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(cnt));
endmodule

// File: rtl/rtc_events.sv
module rtc_events #(
    parameter int W = 32
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [W-1:0]                             cnt,
    input  logic [rtc_pkg::NUM_ALARMS-1:0][W-1:0]    alarm,
    input  logic                                     step,
    input  logic                                     load,
    input  logic                                     status_we,
    input  logic [rtc_pkg::STAT_W-1:0]               status_wd,
    output logic [rtc_pkg::STAT_W-1:0]               status,
    output logic                                     irq
);
    import rtc_pkg::*;

    logic [NUM_ALARMS-1:0] al_flag_q, al_en_q;
    logic                  tick_flag_q, tick_en_q;
    logic                  tick_hit;
    logic                  unused_wd;

    assign unused_wd = ^{status_wd[7], status_wd[5]};

    assign tick_hit = step && !load && (cnt[FRAC_BITS-1:0] == '1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_flag_q <= 1'b0;
            tick_en_q   <= 1'b0;
        end else begin
            if (tick_hit)
                tick_flag_q <= 1'b1;
            else if (status_we && status_wd[B_TICK])
                tick_flag_q <= 1'b0;
            if (status_we)
                tick_en_q <= status_wd[B_TICK_EN];
        end
    end

    for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarm
        localparam int FB = (i == 0) ? B_AL0 : B_AL1;
        localparam int EB = (i == 0) ? B_AL0_EN : B_AL1_EN;
        logic hit;
        assign hit = (cnt == alarm[i]) && al_en_q[i];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                al_flag_q[i] <= 1'b0;
                al_en_q[i]   <= 1'b0;
            end else begin
                if (hit)
                    al_flag_q[i] <= 1'b1;
                else if (status_we && status_wd[FB])
                    al_flag_q[i] <= 1'b0;
                if (status_we)
                    al_en_q[i] <= status_wd[EB];
            end
        end

        // R8
        alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((cnt == alarm[i]) && al_en_q[i]) |=> status[FB]);
        // R9
        alarm_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (status_we && status_wd[FB] && !((cnt == alarm[i]) && al_en_q[i]))
            |=> !status[FB]);
    end

    always_comb begin
        status            = '0;
        status[B_TICK]    = tick_flag_q;
        status[B_TICK_EN] = tick_en_q;
        status[B_AL0]     = al_flag_q[0];
        status[B_AL0_EN]  = al_en_q[0];
        status[B_AL1]     = al_flag_q[1];
        status[B_AL1_EN]  = al_en_q[1];
    end

    always_comb begin
        irq = (tick_flag_q && tick_en_q) || (|(al_flag_q & al_en_q));
    end

    // R10
    tick_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_we && status_wd[B_TICK] && step && !load &&
         cnt[FRAC_BITS-1:0] == '1) |=> status[B_TICK]);
    // R9
    tick_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_we && status_wd[B_TICK] && !step) |=> !status[B_TICK]);
endmodule

// File: rtl/rtc_tick_alarm.sv
module rtc_tick_alarm #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 1023,
    parameter int SEL_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    import rtc_pkg::*;

    logic [DIV_W-1:0]                   div_q;
    logic [SEL_W-1:0]                   sel_q;
    logic [DATA_W-1:0]                  scratch_q;
    logic [NUM_ALARMS-1:0][DATA_W-1:0]  alarm_vec;
    logic [DATA_W-1:0]                  cnt;
    logic [STAT_W-1:0]                  status;
    logic                               step, run;
    logic                               wr_cnt, wr_status;
    logic                               unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:DIV_W];

    assign wr_cnt    = bus_we && (bus_addr == ADDR_W'(OFS_COUNT));
    assign wr_status = bus_we && (bus_addr == ADDR_W'(OFS_STATUS));
    assign run       = (sel_q == SEL_W'(SEL_RUN));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q     <= DIV_W'(DIV_RESET);
            sel_q     <= '0;
            scratch_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_W'(OFS_DIV))     div_q     <= bus_wdata[DIV_W-1:0];
            if (bus_addr == ADDR_W'(OFS_SEL))     sel_q     <= bus_wdata[SEL_W-1:0];
            if (bus_addr == ADDR_W'(OFS_SCRATCH)) scratch_q <= bus_wdata;
        end
    end

    for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_match
        localparam logic [7:0] OFS = (i == 0) ? OFS_ALARM0 : OFS_ALARM1;
        logic [DATA_W-1:0] match_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                match_q <= '0;
            else if (bus_we && bus_addr == ADDR_W'(OFS))
                match_q <= bus_wdata;
        end
        assign alarm_vec[i] = match_q;
    end

    rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_en (osc_en),
        .run    (run),
        .div    (div_q),
        .step   (step)
    );

    rtc_counter #(.W(DATA_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (wr_cnt),
        .load_val (bus_wdata),
        .cnt      (cnt)
    );

    rtc_events #(.W(DATA_W)) u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt       (cnt),
        .alarm     (alarm_vec),
        .step      (step),
        .load      (wr_cnt),
        .status_we (wr_status),
        .status_wd (bus_wdata[STAT_W-1:0]),
        .status    (status),
        .irq       (irq)
    );

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_COUNT):   bus_rdata = cnt;
            ADDR_W'(OFS_ALARM0):  bus_rdata = alarm_vec[0];
            ADDR_W'(OFS_STATUS):  bus_rdata = DATA_W'(status);
            ADDR_W'(OFS_DIV):     bus_rdata = DATA_W'(div_q);
            ADDR_W'(OFS_ALARM1):  bus_rdata = alarm_vec[1];
            ADDR_W'(OFS_SEL):     bus_rdata = DATA_W'(sel_q);
            ADDR_W'(OFS_SCRATCH): bus_rdata = scratch_q;
            default:              bus_rdata = '0;
        endcase
    end

    // R11
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((status[B_AL0] && status[B_AL0_EN]) ||
                 (status[B_TICK] && status[B_TICK_EN]) ||
                 (status[B_AL1] && status[B_AL1_EN])));
endmodule

// File: tb/rtc_tick_alarm_test.sv
module rtc_tick_alarm_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_en = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    typedef struct {
        logic [31:0] exp;
        bit          is_irq;
        string       tag;
    } exp_t;

    exp_t q[$];
    bit   mon_req = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    localparam logic [7:0] A_CNT = 8'h00, A_AL0 = 8'h04, A_ST = 8'h08,
                           A_DIV = 8'h0C, A_AL1 = 8'h18, A_SEL = 8'h1C,
                           A_SCR = 8'h40;

    always #2 clk = ~clk;

    rtc_tick_alarm uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_en    (osc_en),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // monitor: compares at the falling edge
    always @(negedge clk) begin
        if (mon_req && q.size() > 0) begin
            exp_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.is_irq ? {31'b0, irq} : bus_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit osc = 1'b0);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        osc_en    = osc;
        tick();
        bus_we    = 1'b0;
        osc_en    = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int k = 0; k < n; k++) begin
            osc_en = 1'b1;
            tick();
            osc_en = 1'b0;
            tick();
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        bus_addr = a;
        q.push_back('{exp: e, is_irq: 1'b0, tag: tag});
        mon_req = 1'b1;
        tick();
        mon_req = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        q.push_back('{exp: {31'b0, e}, is_irq: 1'b1, tag: tag});
        mon_req = 1'b1;
        tick();
        mon_req = 1'b0;
    endtask

    task automatic restart_presc();
        wr(A_SEL, 32'h0);
        wr(A_SEL, 32'h3);
        tick();
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(A_CNT, 32'h0, "R1 count");
        rd(A_AL0, 32'h0, "R1 alarm0");
        rd(A_AL1, 32'h0, "R1 alarm1");
        rd(A_ST,  32'h0, "R1 status");
        rd(A_DIV, 32'h3FF, "R1 divider");
        rd(A_SEL, 32'h0, "R1 select");
        rd(A_SCR, 32'h0, "R1 scratch");
        chk_irq(1'b0, "R1 irq");
        // R12 unmapped address
        rd(8'h10, 32'h0, "R12 unmapped");

        // R2 scratch word
        wr(A_SCR, 32'hCAFE_0001);
        rd(A_SCR, 32'hCAFE_0001, "R2 scratch");
        rd(A_CNT, 32'h0, "R2 count untouched");

        // R3 divider 1: 4 pulses per step
        wr(A_DIV, 32'h1);
        wr(A_SEL, 32'h3);
        tick();
        rd(A_SEL, 32'h3, "R12 select");
        wr(A_CNT, 32'h10);
        pulse(8);
        rd(A_CNT, 32'h12, "R3 div1");

        // R3 divider 2: 6 pulses per step
        wr(A_DIV, 32'h2);
        restart_presc();
        pulse(12);
        rd(A_CNT, 32'h14, "R3 div2");

        // R4 reserved select halts
        wr(A_SEL, 32'h2);
        tick();
        pulse(8);
        rd(A_CNT, 32'h14, "R4 reserved select");
        wr(A_DIV, 32'h1);
        wr(A_SEL, 32'h3);
        tick();

        // R5 wrap, R7 tick flag
        wr(A_CNT, 32'hFFFF_FFFF);
        pulse(4);
        rd(A_CNT, 32'h0, "R5 wrap");
        rd(A_ST, 32'h02, "R7 tick flag");
        chk_irq(1'b0, "R11 flag without enable");
        wr(A_ST, 32'h08);
        rd(A_ST, 32'h0A, "R9 zero keeps flag");
        chk_irq(1'b1, "R11 tick irq");

        // R10 tick set against clear
        restart_presc();
        wr(A_CNT, 32'h1F);
        pulse(3);
        wr(A_ST, 32'h0A, 1'b1);
        rd(A_ST, 32'h0A, "R10 tick set wins");
        rd(A_CNT, 32'h20, "R3 step on write cycle");
        wr(A_ST, 32'h02);
        rd(A_ST, 32'h00, "R9 tick cleared");
        chk_irq(1'b0, "R11 quiet");

        // R8 alarms
        wr(A_AL0, 32'h21);
        wr(A_AL1, 32'h21);
        wr(A_ST, 32'h04);
        pulse(4);
        rd(A_CNT, 32'h21, "R3 reach alarm");
        rd(A_ST, 32'h05, "R8 alarm0 set, alarm1 disabled");
        chk_irq(1'b1, "R11 alarm0 irq");
        rd(A_AL0, 32'h21, "R12 alarm0 readback");
        wr(A_ST, 32'h05);
        rd(A_ST, 32'h05, "R10 alarm set wins");
        wr(A_ST, 32'h01);
        rd(A_ST, 32'h01, "R10 old enable used");
        wr(A_ST, 32'h01);
        rd(A_ST, 32'h00, "R9 alarm0 cleared");
        chk_irq(1'b0, "R11 alarm0 off");
        wr(A_ST, 32'h40);
        tick();
        rd(A_ST, 32'h50, "R8 alarm1 set");
        chk_irq(1'b1, "R11 alarm1 irq");
        wr(A_CNT, 32'h100);
        wr(A_ST, 32'h10);
        rd(A_ST, 32'h00, "R9 alarm1 cleared");

        // R6 write beats same-cycle increment
        pulse(3);
        wr(A_CNT, 32'h500, 1'b1);
        rd(A_CNT, 32'h500, "R6 write wins");
        pulse(4);
        rd(A_CNT, 32'h501, "R3 after load");

        tick();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule